// File: doc/BRIEF.md
# Swipe Time-out Aggregator

This block watches three magnetic-stripe read channels and decides when a card swipe has ended. Every channel owns an inactivity timer that starts when the channel reports its first peak and restarts on each later peak. The timer only advances on a sample-rate tick. When the number of ticks since the last peak reaches a programmable 12-bit limit, the channel has timed out. The channel then goes idle, but it keeps listening, and its next peak starts a fresh swipe.

Each channel time-out sets a sticky per-track flag. The block also sets a separate sticky card flag, but only when the expiring channel is the last busy one. A channel counts as not busy when it is disabled, has never seen a peak, has already timed out, or is timing out in the same cycle. Software clears each flag by writing a one to it. One interrupt line is raised from the flags whose interrupt enables are set. This lets software take either one interrupt per track or a single interrupt per card.

Top module: `swipe_timeout_agg`

## Requirements
- R1: An enabled track's timer starts on its first peak. The track times out on the tick that makes the count of ticks since its last peak reach `limit`; a `limit` of 0 behaves like 1. The sticky flag `trk_flag[i]` (bit i = track i) reads 1 from the cycle after that tick.
- R2: A peak on an enabled track restarts its timer. A peak in the same cycle as a tick counts as a restart, not as a tick.
- R3: The timers change only in cycles where `tick` is 1. Cycles without a tick leave every timer unchanged.
- R4: After a time-out, the track stays idle until its next peak. That peak rearms it, and a later time-out sets its flag again.
- R5: While `trk_en[i]` is 0, track i ignores peaks, its timer is cleared and it is not started. A track that was disabled in the middle of a swipe does not time out after it is enabled again, until a new peak arrives.
- R6: `card_flag` is set when a track times out and every other track is disabled, not started, or timing out in the same cycle. It is not set if another track is still counting, or if another track starts in that same cycle.
- R7: `trk_flag` and `card_flag` are sticky. A 1 on `clr_trk[i]` or on `clr_card` clears the matching flag. If a set and a clear happen in the same cycle, the set wins.
- R8: `irq` equals the OR of (`trk_flag & trk_ie`) together with (`card_flag & card_ie`). It follows changes to the interrupt enables without delay.
- R9: Reset (`rst_n` low) clears all flags, timers and started state, and it holds `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trk_en | input | NTRK | Per-track enable |
| peak | input | NTRK | Per-track peak strobe |
| tick | input | 1 | Sample-rate tick; timers advance when high |
| limit | input | TW | Time-out limit in ticks |
| trk_ie | input | NTRK | Per-track interrupt enable |
| card_ie | input | 1 | Card time-out interrupt enable |
| clr_trk | input | NTRK | Write-1-to-clear for the per-track flags |
| clr_card | input | 1 | Write-1-to-clear for the card flag |
| trk_flag | output | NTRK | Sticky per-track time-out flags |
| card_flag | output | 1 | Sticky card time-out flag |
| irq | output | 1 | Combined interrupt |

## Verification
The bench uses the default parameters, three tracks with 12-bit timers. The time-out limit is a port, so setting it to 3 makes each swipe finish in a few cycles. With that short limit the bench can reach many last-track situations in a short run: a lone track, two tracks expiring together, a disabled neighbour, and a neighbour starting in the same cycle. The bench also sets the limit to the full 4095 and to 0, which reaches both ends of the counter.

// File: rtl/swipe_timeout_agg.sv
module swipe_timeout_agg #(
  parameter int NTRK = 3,
  parameter int TW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NTRK-1:0] trk_en,
  input  logic [NTRK-1:0] peak,
  input  logic            tick,
  input  logic [TW-1:0]   limit,
  input  logic [NTRK-1:0] trk_ie,
  input  logic            card_ie,
  input  logic [NTRK-1:0] clr_trk,
  input  logic            clr_card,
  output logic [NTRK-1:0] trk_flag,
  output logic            card_flag,
  output logic            irq
);

  logic [TW-1:0]   cnt [NTRK];
  logic [NTRK-1:0] active, expire, idle, last;
  logic            ok;

  for (genvar i = 0; i < NTRK; i++) begin : g_trk
    assign expire[i] = trk_en[i] & active[i] & tick & ~peak[i] &
                       (({1'b0, cnt[i]} + 1'b1) >= {1'b0, limit});
    assign idle[i]   = ~trk_en[i] | (~active[i] & ~peak[i]) | expire[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        active[i] <= 1'b0;
        cnt[i]    <= '0;
      end else if (!trk_en[i] || peak[i]) begin
        active[i] <= trk_en[i];
        cnt[i]    <= '0;
      end else if (expire[i]) begin
        active[i] <= 1'b0;
      end else if (active[i] && tick) begin
        cnt[i]    <= cnt[i] + 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)          trk_flag[i] <= 1'b0;
      else if (expire[i])  trk_flag[i] <= 1'b1;
      else if (clr_trk[i]) trk_flag[i] <= 1'b0;
    end

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trk_flag[i] && !clr_trk[i] |=> trk_flag[i]);
    p_idle_after_timeout_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trk_flag[i]) |-> !active[i]);
    p_disable_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !trk_en[i] |=> !active[i] && cnt[i] == '0);
    p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      trk_en[i] && !peak[i] && !tick |=> $stable(cnt[i]));
  end

  always_comb begin
    last = '0;
    for (int i = 0; i < NTRK; i++) begin
      ok = 1'b1;
      for (int j = 0; j < NTRK; j++)
        if (j != i && !idle[j]) ok = 1'b0;
      last[i] = expire[i] & ok;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        card_flag <= 1'b0;
    else if (|last)    card_flag <= 1'b1;
    else if (clr_card) card_flag <= 1'b0;
  end

  assign irq = (|(trk_flag & trk_ie)) | (card_flag & card_ie);

  p_card_has_track_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_flag) |-> |trk_flag);
  p_reset_quiet_r9: assert property (@(posedge clk)
    !rst_n |=> !card_flag && trk_flag == '0);

endmodule

// File: tb/sim_swipe_timeout_agg.sv
module sim_swipe_timeout_agg;
  localparam int CLK_P = 10;
  localparam int N = 3;

  logic clk = 0, rst_n = 0, tick = 0, card_ie = 1, clr_card = 0;
  logic [N-1:0] trk_en = '1, peak = '0, trk_ie = '1, clr_trk = '0, trk_flag;
  logic [11:0] limit = 12'd3;
  logic card_flag, irq;
  int tests = 0, fails = 0;

  swipe_timeout_agg u0 (.clk, .rst_n, .trk_en, .peak, .tick, .limit, .trk_ie,
    .card_ie, .clr_trk, .clr_card, .trk_flag, .card_flag, .irq);

  always #(CLK_P/2) clk = ~clk;

  // {en[3], peak[3], tick, clr_trk[3], clr_card, exp_trk_flag[3], exp_card}
  localparam logic [14:0] VEC [18] = '{
    15'b111_001_1_000_0_000_0, 15'b111_000_1_000_0_000_0,
    15'b111_010_1_000_0_000_0, 15'b111_000_1_000_0_001_0,
    15'b111_000_0_000_0_001_0, 15'b111_000_1_000_0_001_0,
    15'b111_000_1_000_0_011_1, 15'b111_000_0_011_1_000_0,
    15'b111_101_1_000_0_000_0, 15'b111_000_1_000_0_000_0,
    15'b111_000_1_000_0_000_0, 15'b111_000_1_000_0_101_1,
    15'b111_000_0_101_1_000_0, 15'b011_100_1_000_0_000_0,
    15'b011_001_1_000_0_000_0, 15'b011_000_1_000_0_000_0,
    15'b011_000_1_000_0_000_0, 15'b011_000_1_000_0_001_1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [2:0] en, input logic [2:0] pk, input logic tk,
                     input logic [2:0] ct, input logic cc);
    trk_en = en; peak = pk; tick = tk; clr_trk = ct; clr_card = cc;
    @(posedge clk); #1;
    peak = '0; clr_trk = '0; clr_card = 0; tick = 0;
  endtask

  task automatic clear_all();
    cyc(3'b111, 3'b000, 0, 3'b111, 1);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R9 reset trk_flag", trk_flag, 0);
    chk("R9 reset card_flag", card_flag, 0);
    chk("R9 reset irq", irq, 0);
    rst_n = 1;

    for (int k = 0; k < 18; k++) begin
      cyc(VEC[k][14:12], VEC[k][11:9], VEC[k][8], VEC[k][7:5], VEC[k][4]);
      chk($sformatf("R1/R6/R7 table step %0d trk_flag", k), trk_flag, VEC[k][3:1]);
      chk($sformatf("R6 table step %0d card_flag", k), card_flag, VEC[k][0]);
      chk($sformatf("R8 table step %0d irq", k), irq, (|VEC[k][3:1]) | VEC[k][0]);
    end
    clear_all();

    // R2: restart on peak, peak beats tick
    cyc(3'b111, 3'b001, 1, 0, 0);
    cyc(3'b111, 0, 1, 0, 0); cyc(3'b111, 0, 1, 0, 0);
    cyc(3'b111, 3'b001, 1, 0, 0);
    cyc(3'b111, 0, 1, 0, 0); cyc(3'b111, 0, 1, 0, 0);
    chk("R2 no time-out after restart", trk_flag, 0);
    cyc(3'b111, 0, 1, 0, 0);
    chk("R2 time-out after restart", trk_flag, 3'b001);
    clear_all();

    // R5: disable mid-swipe
    cyc(3'b111, 3'b001, 1, 0, 0);
    cyc(3'b111, 0, 1, 0, 0);
    cyc(3'b110, 3'b001, 1, 0, 0);
    repeat (5) cyc(3'b111, 0, 1, 0, 0);
    chk("R5 no time-out after disable", trk_flag, 0);
    chk("R5 no card after disable", card_flag, 0);

    // R4: rearm after time-out
    cyc(3'b111, 3'b001, 1, 0, 0);
    repeat (3) cyc(3'b111, 0, 1, 0, 0);
    chk("R4 first time-out", trk_flag, 3'b001);
    clear_all();
    repeat (4) cyc(3'b111, 0, 1, 0, 0);
    chk("R4 idle after time-out", trk_flag, 0);
    cyc(3'b111, 3'b001, 1, 0, 0);
    repeat (2) cyc(3'b111, 0, 1, 0, 0);
    chk("R4 rearmed not yet", trk_flag, 0);
    cyc(3'b111, 0, 1, 0, 0);
    chk("R4 rearmed time-out", trk_flag, 3'b001);
    clear_all();

    // R7: set wins over clear
    cyc(3'b111, 3'b001, 1, 0, 0);
    repeat (2) cyc(3'b111, 0, 1, 0, 0);
    cyc(3'b111, 0, 1, 3'b001, 1);
    chk("R7 set beats clear trk", trk_flag, 3'b001);
    chk("R7 set beats clear card", card_flag, 1);

    // R8: interrupt gating
    trk_ie = 0; card_ie = 0; #1;
    chk("R8 all masked", irq, 0);
    card_ie = 1; #1;
    chk("R8 card enable", irq, 1);
    card_ie = 0; trk_ie = 3'b110; #1;
    chk("R8 other track enables", irq, 0);
    trk_ie = 3'b001; #1;
    chk("R8 track enable", irq, 1);
    trk_ie = '1; card_ie = 1;
    clear_all();

    // R6: another track starts in the same cycle
    cyc(3'b111, 3'b001, 1, 0, 0);
    repeat (2) cyc(3'b111, 0, 1, 0, 0);
    cyc(3'b111, 3'b010, 1, 0, 0);
    chk("R6 neighbour start trk", trk_flag, 3'b001);
    chk("R6 neighbour start no card", card_flag, 0);
    repeat (3) cyc(3'b111, 0, 1, 0, 0);
    chk("R6 neighbour then last", card_flag, 1);
    clear_all();

    // R3: no ticks, no progress
    cyc(3'b111, 3'b100, 1, 0, 0);
    repeat (20) cyc(3'b111, 0, 0, 0, 0);
    chk("R3 held without tick", trk_flag, 0);
    repeat (3) cyc(3'b111, 0, 1, 0, 0);
    chk("R3 ticks resume", trk_flag, 3'b100);
    clear_all();

    // R1: full-scale and zero limits
    limit = 12'hFFF;
    cyc(3'b111, 3'b010, 1, 0, 0);
    repeat (4094) cyc(3'b111, 0, 1, 0, 0);
    chk("R1 limit 4095 not yet", trk_flag, 0);
    cyc(3'b111, 0, 1, 0, 0);
    chk("R1 limit 4095 expire", trk_flag, 3'b010);
    clear_all();
    limit = 12'd0;
    cyc(3'b111, 3'b001, 1, 0, 0);
    chk("R1 limit 0 no expire on peak", trk_flag, 0);
    cyc(3'b111, 0, 1, 0, 0);
    chk("R1 limit 0 expire on first tick", trk_flag, 3'b001);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule